// File: doc/BRIEF.md
# Three-Phase Gate Command Interlock

This block is the clocked control path between a motor controller and the three half-bridge legs of a power stage. Each leg has two active-low commands, one for the high-side switch and one for the low-side switch. The block turns them into two active-high gate commands. It rejects input pulses that are too short. It never lets both switches of a leg conduct. It keeps a dead interval between one switch releasing and its partner turning on.

Several conditions override the commands. An enable input, a low-side supply undervoltage flag and a global shutdown request each force every gate low. The shutdown request is normally raised by an over-current detector. Each leg also has a high-side supply undervoltage flag that turns off only that leg's high-side gate. When that flag clears, the high side stays disarmed until the command shows a fresh turn-on edge. A low side, in contrast, follows its filtered command as soon as its blocking condition is gone. All flags arrive clean and synchronous. Filter and dead-time lengths are parameters counted in clock cycles.

Top module: `gate_interlock`

## Requirements
- R1: After reset every gate output is low, every filtered command reads off, and the dead interval counts as already elapsed, so the first turn-on waits only for the filter.
- R2: Commands are active low: a 0 on `hi_cmd_n[i]` or `lo_cmd_n[i]` requests that gate on, and a 1 requests it off.
- R3: A command level must be sampled on FILT_CYC consecutive clock edges before the filtered command follows it; a shorter pulse leaves the gate output unchanged.
- R4: When nothing blocks it, an accepted command change reaches the gate output FILT_CYC+1 clock edges after the first edge that samples the new level.
- R5: `hi_gate[i]` and `lo_gate[i]` are never high in the same cycle.
- R6: A gate output of a leg may rise only on a clock edge at least DEAD_CYC+1 edges after the most recent falling edge of either output of that leg.
- R7: While both filtered commands of a leg request on, both gates of that leg are driven low; once one command is released, the other side may turn on subject to R6.
- R8: With `enable` low, every gate output is low on the next clock edge, whatever the other inputs are.
- R9: While `vcc_uv` is high every gate output is low; after it clears, each low-side gate takes its filtered command state on the next edge allowed by R6.
- R10: While `vbs_uv[i]` is high, `hi_gate[i]` is low. After any edge that samples it high, `hi_gate[i]` stays low until the filtered high-side command goes from off to on with `vbs_uv[i]` low; a command held on throughout does not restore it.
- R11: With `shutdown` high, every gate output is low on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cmd_n | input | LEGS | High-side commands, active low, one bit per leg |
| lo_cmd_n | input | LEGS | Low-side commands, active low, one bit per leg |
| enable | input | 1 | Gate enable; low forces all gates off |
| vcc_uv | input | 1 | Low-side supply undervoltage flag |
| vbs_uv | input | LEGS | High-side supply undervoltage flags, one per leg |
| shutdown | input | 1 | Global shutdown request from the fault path |
| hi_gate | output | LEGS | High-side gate commands, active high |
| lo_gate | output | LEGS | Low-side gate commands, active high |

## Verification
The bench sends pulses one cycle shorter than the filter and pulses exactly as long as it. A filter off by one edge either lets a glitch through or swallows a valid command. It hands a leg straight from one side to the other and checks the measured gap. A dead counter that starts on the wrong edge, or that ignores the partner's fall, turns the partner on too early and shoots through the leg. It requests both sides at once, and a priority encoder in place of a lockout would show up as one side staying on. It also holds the high-side command on across a high-side undervoltage. A design that re-arms on the level instead of a fresh edge turns the gate back on when the flag clears. Long random runs then mix all of these with enable, shutdown and undervoltage events.

// File: rtl/gate_interlock.sv
module gate_interlock #(
  parameter int LEGS     = 3,
  parameter int FILT_CYC = 38,
  parameter int DEAD_CYC = 39
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LEGS-1:0] hi_cmd_n,
  input  logic [LEGS-1:0] lo_cmd_n,
  input  logic            enable,
  input  logic            vcc_uv,
  input  logic [LEGS-1:0] vbs_uv,
  input  logic            shutdown,
  output logic [LEGS-1:0] hi_gate,
  output logic [LEGS-1:0] lo_gate
);
  localparam int FW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [FW-1:0] FLAST = FW'(FILT_CYC - 1);
  localparam logic [DW-1:0] DLAST = DW'(DEAD_CYC);

  logic kill_all;
  assign kill_all = !enable || vcc_uv || shutdown;

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    logic          fh, fl, arm, hq, lq;
    logic [FW-1:0] ch, cl;
    logic [DW-1:0] dcnt;
    logic          rh, rl, fh_nx, fl_nx;
    logic          want_h, want_l, dexp, hn, ln, fall;

    assign rh    = ~hi_cmd_n[g];
    assign rl    = ~lo_cmd_n[g];
    assign fh_nx = (rh != fh && ch == FLAST) ? rh : fh;
    assign fl_nx = (rl != fl && cl == FLAST) ? rl : fl;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fh  <= 1'b0;
        fl  <= 1'b0;
        ch  <= '0;
        cl  <= '0;
        arm <= 1'b0;
      end else begin
        fh <= fh_nx;
        fl <= fl_nx;
        ch <= (rh == fh || ch == FLAST) ? '0 : ch + 1'b1;
        cl <= (rl == fl || cl == FLAST) ? '0 : cl + 1'b1;
        if (vbs_uv[g])          arm <= 1'b0;
        else if (fh_nx && !fh)  arm <= 1'b1;
      end
    end

    assign want_h = fh & ~fl & arm & ~kill_all & ~vbs_uv[g];
    assign want_l = fl & ~fh & ~kill_all;
    assign dexp   = (dcnt == DLAST);
    assign hn     = want_h & ~lq & (hq | dexp);
    assign ln     = want_l & ~hq & (lq | dexp);
    assign fall   = (hq & ~hn) | (lq & ~ln);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hq   <= 1'b0;
        lq   <= 1'b0;
        dcnt <= DLAST;
      end else begin
        hq <= hn;
        lq <= ln;
        if (fall)        dcnt <= '0;
        else if (!dexp)  dcnt <= dcnt + 1'b1;
      end
    end

    assign hi_gate[g] = hq;
    assign lo_gate[g] = lq;

    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_gate[g] && lo_gate[g]));
    a_r6_hi_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_gate[g]) |-> !$past(lo_gate[g]) && !$past(lo_gate[g], 2));
    a_r6_lo_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_gate[g]) |-> !$past(hi_gate[g]) && !$past(hi_gate[g], 2));
    a_r10_hs_uv: assert property (@(posedge clk) disable iff (!rst_n)
      vbs_uv[g] |=> !hi_gate[g]);
    a_r10_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_gate[g]) |-> !$past(vbs_uv[g]));
  end

  a_r8_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (hi_gate == '0 && lo_gate == '0));
  a_r9_vcc_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_uv |=> (hi_gate == '0 && lo_gate == '0));
  a_r11_shutdown_off: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (hi_gate == '0 && lo_gate == '0));
endmodule

// File: tb/sim_gate_interlock.sv
module sim_gate_interlock;
  localparam int L = 3;
  localparam int F = 6;
  localparam int D = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n;
  logic [L-1:0] hi_cmd_n, lo_cmd_n, vbs_uv, hi_gate, lo_gate;
  logic         enable, vcc_uv, shutdown;

  gate_interlock #(.LEGS(L), .FILT_CYC(F), .DEAD_CYC(D)) u0 (
    .clk(clk), .rst_n(rst_n), .hi_cmd_n(hi_cmd_n), .lo_cmd_n(lo_cmd_n),
    .enable(enable), .vcc_uv(vcc_uv), .vbs_uv(vbs_uv), .shutdown(shutdown),
    .hi_gate(hi_gate), .lo_gate(lo_gate));

  int    vecs = 0, bad = 0, cyc = 0;
  bit    running = 0;
  string tag = "R1";

  bit mfh[L], mfl[L], marm[L], mhq[L], mlq[L], prh[L], prl[L], pdh[L], pdl[L];
  int runh[L], runl[L], mlf[L], olf[L];

  task automatic cmp(string t, string what, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", t, what, act, exp, cyc);
    end
  endtask

  task automatic mreset();
    for (int i = 0; i < L; i++) begin
      mfh[i] = 0; mfl[i] = 0; marm[i] = 0; mhq[i] = 0; mlq[i] = 0;
      prh[i] = 0; prl[i] = 0; pdh[i] = 0; pdl[i] = 0;
      runh[i] = 0; runl[i] = 0; mlf[i] = -1000; olf[i] = -1000;
    end
  endtask

  task automatic mstep();
    bit kill, wh, wl, ex, nh, nl, rh, rl, ofh;
    kill = !enable || vcc_uv || shutdown;
    for (int i = 0; i < L; i++) begin
      wh = mfh[i] && !mfl[i] && marm[i] && !kill && !vbs_uv[i];
      wl = mfl[i] && !mfh[i] && !kill;
      ex = (cyc - mlf[i]) > D;
      nh = wh && !mlq[i] && (mhq[i] || ex);
      nl = wl && !mhq[i] && (mlq[i] || ex);
      if ((mhq[i] && !nh) || (mlq[i] && !nl)) mlf[i] = cyc;
      mhq[i] = nh; mlq[i] = nl;
      rh = !hi_cmd_n[i]; rl = !lo_cmd_n[i];
      runh[i] = (rh == prh[i]) ? runh[i] + 1 : 1; prh[i] = rh;
      runl[i] = (rl == prl[i]) ? runl[i] + 1 : 1; prl[i] = rl;
      ofh = mfh[i];
      if (runh[i] >= F) mfh[i] = rh;
      if (runl[i] >= F) mfl[i] = rl;
      if (vbs_uv[i]) marm[i] = 0;
      else if (mfh[i] && !ofh) marm[i] = 1;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (running) begin
      cyc++;
      mstep();
      for (int i = 0; i < L; i++) begin
        cmp(tag, $sformatf("hi_gate[%0d]", i), hi_gate[i], mhq[i]);
        cmp(tag, $sformatf("lo_gate[%0d]", i), lo_gate[i], mlq[i]);
        cmp("R5", $sformatf("overlap leg %0d", i), hi_gate[i] & lo_gate[i], 1'b0);
        if ((hi_gate[i] && !pdh[i]) || (lo_gate[i] && !pdl[i]))
          cmp("R6", $sformatf("gap ok leg %0d", i), 1'((cyc - olf[i]) > D), 1'b1);
        if ((!hi_gate[i] && pdh[i]) || (!lo_gate[i] && pdl[i])) olf[i] = cyc;
        pdh[i] = hi_gate[i]; pdl[i] = lo_gate[i];
      end
    end
  endtask

  task automatic hold(int n);
    repeat (n) tick();
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; hi_cmd_n = '1; lo_cmd_n = '1; vbs_uv = '0;
    enable = 1; vcc_uv = 0; shutdown = 0;
    hold(4);
    rst_n = 1; mreset(); running = 1;
    cmp("R1", "hi_gate after reset", |hi_gate, 1'b0);
    cmp("R1", "lo_gate after reset", |lo_gate, 1'b0);

    tag = "R2 R4 level";
    lo_cmd_n[0] = 0; hold(F);
    cmp("R4", "lo_gate[0] one edge early", lo_gate[0], 1'b0);
    hold(1);
    cmp("R4", "lo_gate[0] on time", lo_gate[0], 1'b1);
    hold(4);
    lo_cmd_n[0] = 1; hold(12);

    tag = "R3 short";
    lo_cmd_n[1] = 0; hold(F - 1); lo_cmd_n[1] = 1; hold(10);
    cmp("R3", "lo_gate[1] after short pulse", lo_gate[1], 1'b0);
    hi_cmd_n[1] = 0; hold(F - 1); hi_cmd_n[1] = 1; hold(10);
    cmp("R3", "hi_gate[1] after short pulse", hi_gate[1], 1'b0);
    hi_cmd_n[1] = 0; hold(F); hi_cmd_n[1] = 1; hold(12);

    tag = "R7 conflict";
    hi_cmd_n[0] = 0; lo_cmd_n[0] = 0; hold(15);
    cmp("R7", "both requested hi", hi_gate[0], 1'b0);
    cmp("R7", "both requested lo", lo_gate[0], 1'b0);
    lo_cmd_n[0] = 1; hold(15);
    cmp("R7", "hi after release", hi_gate[0], 1'b1);
    hi_cmd_n[0] = 1; hold(12);

    tag = "R6 handover";
    hi_cmd_n[2] = 0; hold(15);
    hi_cmd_n[2] = 1; lo_cmd_n[2] = 0; hold(20);
    lo_cmd_n[2] = 1; hi_cmd_n[2] = 0; hold(20);
    hi_cmd_n[2] = 1; hold(12);

    tag = "R8 enable";
    lo_cmd_n[1] = 0; hold(12);
    enable = 0; hold(1);
    cmp("R8", "lo_gate[1] with enable low", lo_gate[1], 1'b0);
    hold(3); enable = 1; hold(12);

    tag = "R9 vcc_uv";
    vcc_uv = 1; hold(8);
    cmp("R9", "lo_gate[1] during vcc_uv", lo_gate[1], 1'b0);
    vcc_uv = 0; hold(1);
    cmp("R9", "lo_gate[1] after vcc_uv", lo_gate[1], 1'b1);
    lo_cmd_n[1] = 1; hold(12);

    tag = "R10 vbs_uv";
    hi_cmd_n[0] = 0; hold(12);
    vbs_uv[0] = 1; hold(3); vbs_uv[0] = 0; hold(15);
    cmp("R10", "hi_gate[0] held command no rearm", hi_gate[0], 1'b0);
    hi_cmd_n[0] = 1; hold(10); hi_cmd_n[0] = 0; hold(F + 2);
    cmp("R10", "hi_gate[0] rearmed by edge", hi_gate[0], 1'b1);
    hi_cmd_n[0] = 1; hold(12);

    tag = "R11 shutdown";
    lo_cmd_n[2] = 0; hold(12);
    shutdown = 1; hold(1);
    cmp("R11", "lo_gate[2] at shutdown", lo_gate[2], 1'b0);
    hold(5); shutdown = 0; hold(12);
    lo_cmd_n[2] = 1; hold(12);

    tag = "R5 R6 R10 random";
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < L; i++) begin
        if ($urandom % 6 == 0) hi_cmd_n[i] = ~hi_cmd_n[i];
        if ($urandom % 6 == 0) lo_cmd_n[i] = ~lo_cmd_n[i];
        if ($urandom % 150 == 0) vbs_uv[i] = ~vbs_uv[i];
      end
      if ($urandom % 200 == 0) enable = ~enable;
      if ($urandom % 250 == 0) vcc_uv = ~vcc_uv;
      if ($urandom % 250 == 0) shutdown = ~shutdown;
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule